// File: doc/BRIEF.md
# SPI FIFO Threshold Monitor and Word Counter

This block watches the transmit and receive FIFOs of one SPI channel. It does not hold the FIFO storage or the shifter. It takes the occupancy of each FIFO and the strobes from the shifter, and it decides when to ask a DMA engine for service. The transmit side asks once free space reaches an almost-empty threshold. The receive side asks once occupancy reaches an almost-full threshold. It also emits single-cycle events for the interrupt unit: threshold crossings, transmit underflow, receive overflow, and an end-of-transfer pulse.

Software writes one packed 32-bit transfer-level word. Each threshold is stored as the wanted level minus one. A 16-bit count holds the number of words in a transfer. The word counter counts completed words while the channel is enabled. It pulses end-of-transfer when the programmed number of words has completed.

All outputs are registered, so each reacts in the cycle after the inputs that cause it. The block has no data path, so no valid/ready handshake is needed. Every pin is a plain level or a single-cycle strobe and carries no back-pressure.

Top module: `spi_xfer_level`

## Requirements
- R1: The configuration word `xfer_cfg` holds the transmit threshold in bits 7:0, the receive threshold in bits 15:8 and the word count in bits 31:16.
- R2: `tx_dma_req` is high in the cycle after a cycle in which the FIFO depth minus `tx_level` was at least the transmit threshold field plus one, with `tx_fifo_en` and `tx_dma_en` both high. Otherwise it is low.
- R3: `rx_dma_req` is high in the cycle after a cycle in which `rx_level` was at least the receive threshold field plus one, with `rx_fifo_en` and `rx_dma_en` both high. Otherwise it is low.
- R4: When a FIFO enable is low, that side raises neither a request nor a threshold event. When only the DMA enable is low, the request stays low but the threshold event still fires.
- R5: `tx_thr_evt` is a one-cycle pulse in the cycle after the transmit threshold condition becomes true. It does not repeat while the condition holds.
- R6: `rx_thr_evt` is a one-cycle pulse in the cycle after the receive threshold condition becomes true. It does not repeat while the condition holds.
- R7: Each `word_done` strobe with `chan_en` high counts one word. In the cycle after the strobe that completes the programmed count, `eow_evt` pulses and counting restarts from zero.
- R8: A programmed word count of zero never produces `eow_evt`.
- R9: While `chan_en` is low the word counter is held at zero, so a transfer that is re-enabled counts from zero.
- R10: `tx_underflow` pulses in the cycle after `tx_pull` is high while `tx_level` is 0 and `tx_fifo_en` is high.
- R11: `rx_overflow` pulses in the cycle after `rx_load` is high while `rx_level` equals the FIFO depth and `rx_fifo_en` is high.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low clears the word counter |
| xfer_cfg | input | 32 | Packed thresholds and word count |
| tx_fifo_en | input | 1 | Transmit FIFO in use |
| rx_fifo_en | input | 1 | Receive FIFO in use |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_level | input | CW | Transmit FIFO occupancy |
| rx_level | input | CW | Receive FIFO occupancy |
| tx_pull | input | 1 | Shifter takes a word from the transmit FIFO |
| rx_load | input | 1 | Shifter delivers a word to the receive FIFO |
| word_done | input | 1 | One SPI word completed |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_thr_evt | output | 1 | Transmit almost-empty event pulse |
| rx_thr_evt | output | 1 | Receive almost-full event pulse |
| eow_evt | output | 1 | End-of-word-count event pulse |
| tx_underflow | output | 1 | Transmit underflow event pulse |
| rx_overflow | output | 1 | Receive overflow event pulse |

## Verification
The last word of a transfer and a receive overflow can land in the same cycle. This happens when the shifter finishes the final word and loads it into a full receive FIFO. The bench programs a count of one and raises `word_done` together with `rx_load` at full occupancy. It expects `eow_evt` and `rx_overflow` together in the next cycle. In a similar way, a threshold crossing is driven in the same cycle as a pull from an empty transmit FIFO, and both pulses must appear together.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  // Field placement matters: software packs this word.
  typedef struct packed {
    logic [15:0] word_cnt;
    logic [7:0]  rx_thr_m1;
    logic [7:0]  tx_thr_m1;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_lvl_cmp.sv
// Threshold comparator for one FIFO side; USE_FREE selects free-space view.
module spi_lvl_cmp #(
  parameter int DEPTH    = 64,
  parameter bit USE_FREE = 1'b0,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          dma_en,
  input  logic [CW-1:0] level,
  input  logic [7:0]    thr_m1,
  output logic          req,
  output logic          evt
);
  localparam int CMPW = ((CW > 8) ? CW : 8) + 1;

  logic [CMPW-1:0] view;
  logic [CMPW-1:0] need;
  logic            hit;
  logic            hit_q;

  generate
    if (USE_FREE) begin : g_free
      assign view = CMPW'(DEPTH) - CMPW'(level);
    end else begin : g_occ
      assign view = CMPW'(level);
    end
  endgenerate

  assign need = CMPW'(thr_m1) + CMPW'(1);
  assign hit  = fifo_en && (view >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      req   <= 1'b0;
      evt   <= 1'b0;
    end else begin
      hit_q <= hit;
      req   <= hit && dma_en;
      evt   <= hit && !hit_q;
    end
  end
endmodule

// File: rtl/spi_lvl_fault.sv
// Flags a strobe that meets a FIFO at its empty or full bound.
module spi_lvl_fault #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          strobe,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] bound,
  output logic          flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= fifo_en && strobe && (level == bound);
  end
endmodule

// File: rtl/spi_word_ctr.sv
// Counts completed words and pulses at the programmed total.
module spi_word_ctr #(
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chan_en,
  input  logic           word_done,
  input  logic [WCW-1:0] target,
  output logic           eow
);
  logic [WCW-1:0] cnt;
  logic [WCW-1:0] cnt_nx;

  assign cnt_nx = cnt + WCW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      eow <= 1'b0;
    end else if (!chan_en) begin
      cnt <= '0;
      eow <= 1'b0;
    end else if (word_done) begin
      if (target != '0 && cnt_nx == target) begin
        cnt <= '0;
        eow <= 1'b1;
      end else begin
        cnt <= cnt_nx;
        eow <= 1'b0;
      end
    end else begin
      eow <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_xfer_level.sv
module spi_xfer_level #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic [31:0]   xfer_cfg,
  input  logic          tx_fifo_en,
  input  logic          rx_fifo_en,
  input  logic          tx_dma_en,
  input  logic          rx_dma_en,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic          tx_pull,
  input  logic          rx_load,
  input  logic          word_done,
  output logic          tx_dma_req,
  output logic          rx_dma_req,
  output logic          tx_thr_evt,
  output logic          rx_thr_evt,
  output logic          eow_evt,
  output logic          tx_underflow,
  output logic          rx_overflow
);
  import spi_xfer_pkg::*;

  xfer_cfg_t cfg;
  assign cfg = xfer_cfg_t'(xfer_cfg);

  spi_lvl_cmp #(.DEPTH(DEPTH), .USE_FREE(1'b1)) u_tx_cmp (
    .clk(clk), .rst_n(rst_n), .fifo_en(tx_fifo_en), .dma_en(tx_dma_en),
    .level(tx_level), .thr_m1(cfg.tx_thr_m1), .req(tx_dma_req), .evt(tx_thr_evt)
  );

  spi_lvl_cmp #(.DEPTH(DEPTH), .USE_FREE(1'b0)) u_rx_cmp (
    .clk(clk), .rst_n(rst_n), .fifo_en(rx_fifo_en), .dma_en(rx_dma_en),
    .level(rx_level), .thr_m1(cfg.rx_thr_m1), .req(rx_dma_req), .evt(rx_thr_evt)
  );

  spi_lvl_fault #(.CW(CW)) u_tx_fault (
    .clk(clk), .rst_n(rst_n), .fifo_en(tx_fifo_en), .strobe(tx_pull),
    .level(tx_level), .bound('0), .flag(tx_underflow)
  );

  spi_lvl_fault #(.CW(CW)) u_rx_fault (
    .clk(clk), .rst_n(rst_n), .fifo_en(rx_fifo_en), .strobe(rx_load),
    .level(rx_level), .bound(CW'(DEPTH)), .flag(rx_overflow)
  );

  spi_word_ctr #(.WCW(16)) u_words (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .word_done(word_done),
    .target(cfg.word_cnt), .eow(eow_evt)
  );
endmodule

// File: rtl/spi_xfer_level_chk.sv
module spi_xfer_level_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic [31:0]   xfer_cfg,
  input logic          tx_fifo_en,
  input logic          rx_fifo_en,
  input logic          tx_dma_en,
  input logic          rx_dma_en,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          tx_pull,
  input logic          rx_load,
  input logic          word_done,
  input logic          tx_dma_req,
  input logic          rx_dma_req,
  input logic          tx_thr_evt,
  input logic          rx_thr_evt,
  input logic          eow_evt,
  input logic          tx_underflow,
  input logic          rx_overflow
);
  AST_TX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) tx_dma_req |-> $past(tx_fifo_en && tx_dma_en)); // R4
  AST_TX_REQ_SPACE: assert property (@(posedge clk) disable iff (!rst_n) tx_dma_req |-> (int'($past(tx_level)) + int'($past(xfer_cfg[7:0])) + 1 <= DEPTH)); // R2
  AST_RX_REQ_FILL: assert property (@(posedge clk) disable iff (!rst_n) rx_dma_req |-> (int'($past(rx_level)) >= int'($past(xfer_cfg[15:8])) + 1)); // R3
  AST_TX_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tx_thr_evt |=> !tx_thr_evt); // R5
  AST_RX_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_thr_evt |=> !rx_thr_evt); // R6
  AST_EOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) eow_evt |-> $past(word_done && chan_en)); // R7
  AST_EOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) eow_evt |-> ($past(xfer_cfg[31:16]) != 16'd0)); // R8
  AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) tx_underflow |-> $past(tx_pull && tx_fifo_en && tx_level == '0)); // R10
  AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rx_overflow |-> $past(rx_load && rx_fifo_en && int'(rx_level) == DEPTH)); // R11
endmodule

bind spi_xfer_level spi_xfer_level_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/spi_xfer_level_bench.sv
module spi_xfer_level_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0;
  logic [31:0] xfer_cfg = '0;
  logic tx_fifo_en = 1'b0, rx_fifo_en = 1'b0, tx_dma_en = 1'b0, rx_dma_en = 1'b0;
  logic [CW-1:0] tx_level = '0, rx_level = '0;
  logic tx_pull = 1'b0, rx_load = 1'b0, word_done = 1'b0;
  logic tx_dma_req, rx_dma_req, tx_thr_evt, rx_thr_evt, eow_evt, tx_underflow, rx_overflow;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_level #(.DEPTH(DEPTH)) u_spi_xfer_level (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [15:0] wc, input logic [7:0] rxt, input logic [7:0] txt);
    xfer_cfg = {wc, rxt, txt};
  endtask

  task automatic quiet();
    tx_fifo_en = 0; rx_fifo_en = 0; tx_dma_en = 0; rx_dma_en = 0;
    tx_pull = 0; rx_load = 0; word_done = 0; chan_en = 0;
    tx_level = '0; rx_level = '0;
    step(); step();
  endtask

  task automatic t_reset();
    check(tx_dma_req | rx_dma_req | tx_thr_evt | rx_thr_evt, 1'b0, "R12 req/evt");
    check(eow_evt | tx_underflow | rx_overflow, 1'b0, "R12 pulses");
  endtask

  task automatic t_tx_thr();
    quiet();
    set_cfg(16'd0, 8'd0, 8'd7);  // R1: tx level 8 in bits 7:0
    tx_fifo_en = 1; tx_dma_en = 1; tx_level = CW'(60);
    step();
    check(tx_dma_req, 1'b0, "R2 free 4 below 8");
    tx_level = CW'(56);
    step();
    check(tx_dma_req, 1'b1, "R2 free 8 reaches 8");
    check(tx_thr_evt, 1'b1, "R5 tx crossing");
    step();
    check(tx_dma_req, 1'b1, "R2 held");
    check(tx_thr_evt, 1'b0, "R5 no repeat");
    tx_level = CW'(57);
    step();
    check(tx_dma_req, 1'b0, "R2 free 7");
  endtask

  task automatic t_rx_thr();
    quiet();
    set_cfg(16'd0, 8'd3, 8'd0);  // R1: rx level 4 in bits 15:8
    rx_fifo_en = 1; rx_dma_en = 1; rx_level = CW'(3);
    step();
    check(rx_dma_req, 1'b0, "R3 occ 3");
    rx_level = CW'(4);
    step();
    check(rx_dma_req, 1'b1, "R3 occ 4");
    check(rx_thr_evt, 1'b1, "R6 rx crossing");
    step();
    check(rx_thr_evt, 1'b0, "R6 no repeat");
  endtask

  task automatic t_gate();
    quiet();
    set_cfg(16'd0, 8'd0, 8'd0);
    rx_fifo_en = 1; rx_dma_en = 0; rx_level = CW'(10);
    step();
    check(rx_dma_req, 1'b0, "R4 dma off no req");
    check(rx_thr_evt, 1'b1, "R4 dma off evt");
    quiet();
    rx_dma_en = 1; rx_level = CW'(10);
    tx_dma_en = 1; tx_level = '0;
    step();
    check(rx_dma_req | rx_thr_evt, 1'b0, "R4 rx fifo off");
    check(tx_dma_req | tx_thr_evt, 1'b0, "R4 tx fifo off");
  endtask

  task automatic t_words();
    quiet();
    set_cfg(16'd3, 8'd0, 8'd0);
    chan_en = 1;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 3; i++) begin
        word_done = 1;
        step();
        check(eow_evt, (i == 2), "R7 word count 3");
      end
      word_done = 0;
      step();
      check(eow_evt, 1'b0, "R7 eow single");
    end
  endtask

  task automatic t_zero();
    quiet();
    set_cfg(16'd0, 8'd0, 8'd0);
    chan_en = 1; word_done = 1;
    for (int i = 0; i < 5; i++) begin
      step();
      check(eow_evt, 1'b0, "R8 count zero");
    end
  endtask

  task automatic t_chan();
    quiet();
    set_cfg(16'd3, 8'd0, 8'd0);
    chan_en = 1; word_done = 1;
    step(); step();
    word_done = 0; chan_en = 0;
    step();
    chan_en = 1; word_done = 1;
    step();
    check(eow_evt, 1'b0, "R9 first after re-enable");
    step();
    check(eow_evt, 1'b0, "R9 second after re-enable");
    step();
    check(eow_evt, 1'b1, "R9 third after re-enable");
  endtask

  task automatic t_underflow();
    quiet();
    tx_fifo_en = 1; tx_pull = 1; tx_level = '0;
    step();
    check(tx_underflow, 1'b1, "R10 pull empty");
    tx_level = CW'(1);
    step();
    check(tx_underflow, 1'b0, "R10 pull non-empty");
    tx_level = '0; tx_fifo_en = 0;
    step();
    check(tx_underflow, 1'b0, "R10 fifo off");
  endtask

  task automatic t_overflow();
    quiet();
    rx_fifo_en = 1; rx_load = 1; rx_level = CW'(DEPTH);
    step();
    check(rx_overflow, 1'b1, "R11 load full");
    rx_level = CW'(DEPTH - 1);
    step();
    check(rx_overflow, 1'b0, "R11 load not full");
  endtask

  task automatic t_coincide();
    quiet();
    set_cfg(16'd1, 8'd0, 8'd3);
    chan_en = 1; rx_fifo_en = 1; tx_fifo_en = 1;
    tx_level = CW'(62);
    step();
    word_done = 1; rx_load = 1; rx_level = CW'(DEPTH);
    tx_level = '0; tx_pull = 1;
    step();
    check(eow_evt, 1'b1, "R7 eow with overflow");
    check(rx_overflow, 1'b1, "R11 overflow with eow");
    check(tx_thr_evt, 1'b1, "R5 crossing with underflow");
    check(tx_underflow, 1'b1, "R10 underflow with crossing");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_thr();
    t_rx_thr();
    t_gate();
    t_words();
    t_zero();
    t_chan();
    t_underflow();
    t_overflow();
    t_coincide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule